// File: doc/BRIEF.md
# Filtered Quadrature Position Counter

This block turns the two phase-shifted square waves of an incremental rotary or linear encoder into a signed position value. Each raw channel is asynchronous to the system clock. It first passes through a two-flop synchronizer. A level qualifier then accepts a new level only after three consecutive identical samples. The qualified channel pair forms one of four phases, and a step decoder compares each phase with the one before it to find the direction of motion.

A two-bit resolution select decides which phase entries produce a count. In full resolution every edge of either channel counts. In half resolution a count occurs on every second edge, and in quarter resolution once per full cycle. The resulting up and down enables drive a 32-bit binary counter. The counter wraps in both directions, so software reads its value as a two's-complement relative position.

If both qualified channels change in the same cycle, the block cannot know the direction of motion. In that case it drops the step and raises a sticky fault flag. Only reset clears the flag.

Top module: `qdc_top`

## Requirements
- R1: A channel's qualified level changes only after the synchronized input has shown the new level on three consecutive rising clock edges. A pulse that lasts two clock periods produces no count, and an interrupted run restarts the qualification.
- R2: Each raw input passes two synchronizer flops. A raw change that is stable before rising edge k updates `pos_o` at edge k+5 and not earlier, which is one clock after the level is qualified.
- R3: The phases are numbered in the up direction as P0=(A,B)=(1,0), P1=(1,1), P2=(0,1) and P3=(0,0). Moving to the next phase is forward, and moving to the previous phase is backward. In full resolution (`res_i` = 00), every forward step adds one and every backward step subtracts one.
- R4: In half resolution (`res_i` = 01), a forward step counts up only on entry to P0 or P2, and a backward step counts down only on entry to P1 or P3.
- R5: In quarter resolution (`res_i` = 10), a forward step counts up only on entry to P0, and a backward step counts down only on entry to P1.
- R6: The select code 11 behaves exactly as full resolution.
- R7: `rst_n` low at a rising edge clears `pos_o` to zero, clears `fault_o`, and sets the qualified phase to P3 (both channels low). The reset is synchronous and active low.
- R8: The count wraps modulo 2^32. One backward step from zero gives 32'hFFFF_FFFF, and one forward step from there gives zero.
- R9: If both qualified channels change in the same cycle, the count is left unchanged and `fault_o` is set one cycle later. `fault_o` then stays high until reset.
- R10: `pos_o` changes by at most one per clock cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; everything updates on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| res_i | input | 2 | Resolution select: 00 full, 01 half, 10 quarter, 11 full |
| enc_a_i | input | 1 | Raw encoder channel A (asynchronous) |
| enc_b_i | input | 1 | Raw encoder channel B (asynchronous) |
| pos_o | output | 32 | Registered position count, two's complement |
| fault_o | output | 1 | Sticky flag for a step that changed both channels at once |

## Verification
A raw input change made between edges reaches `pos_o` and `fault_o` at the sixth rising edge after it: two synchronizer edges, three qualifying samples, and one counter update. The directed latency check samples the outputs on the falling edge after the fifth rising edge, where the old value is still expected, and again after the sixth, where the new value is due. All other stimuli are driven on a falling edge and held for eight clocks before the outputs are compared, so every check falls after the update is due and before the next change. The glitch checks drive pulses of two and three clocks, which lie on either side of the qualification threshold.

// File: rtl/qdc_pkg.sv
package qdc_pkg;

    typedef enum logic [1:0] {
        RES_FULL = 2'b00,
        RES_HALF = 2'b01,
        RES_QTR  = 2'b10,
        RES_ALT  = 2'b11
    } res_e;

    typedef struct packed {
        logic a;
        logic b;
    } quad_t;

    typedef struct packed {
        logic up;
        logic dn;
        logic both;
    } step_t;

    // Ring position of a channel pair in the forward direction
    function automatic logic [1:0] phase_of(quad_t q);
        logic [1:0] ph;
        unique case ({q.a, q.b})
            2'b10:   ph = 2'd0;
            2'b11:   ph = 2'd1;
            2'b01:   ph = 2'd2;
            default: ph = 2'd3;
        endcase
        return ph;
    endfunction

endpackage

// File: rtl/qdc_chan_filter.sv
module qdc_chan_filter #(
    parameter int SYNC_STAGES = 2,
    parameter int HOLD        = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic raw_i,
    output logic level_o
);
    localparam int HW = HOLD - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic [HW-1:0]          hist_q;
    logic [HW:0]            window;
    logic                   smp;
    logic                   level_q;

    assign smp    = sync_q[SYNC_STAGES-1];
    assign window = {hist_q, smp};

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q  <= '0;
            hist_q  <= '0;
            level_q <= 1'b0;
        end else begin
            sync_q <= {sync_q[SYNC_STAGES-2:0], raw_i};
            hist_q <= window[HW-1:0];
            if (&window)
                level_q <= 1'b1;
            else if (~|window)
                level_q <= 1'b0;
        end
    end

    assign level_o = level_q;
endmodule

// File: rtl/qdc_step_decode.sv
module qdc_step_decode
    import qdc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] res_i,
    input  quad_t      cur_i,
    output quad_t      prev_o,
    output step_t      step_o,
    output logic       fault_o
);
    quad_t      prev_q;
    logic       fault_q;
    logic [1:0] p_ph, c_ph;
    logic       fwd, bwd, both;
    step_t      step;

    always_comb begin
        p_ph = phase_of(prev_q);
        c_ph = phase_of(cur_i);
        fwd  = (c_ph == p_ph + 2'd1);
        bwd  = (c_ph == p_ph - 2'd1);
        both = (cur_i.a != prev_q.a) && (cur_i.b != prev_q.b);
        step      = '0;
        step.both = both;
        unique case (res_e'(res_i))
            RES_HALF: begin
                step.up = fwd && !c_ph[0];
                step.dn = bwd &&  c_ph[0];
            end
            RES_QTR: begin
                step.up = fwd && (c_ph == 2'd0);
                step.dn = bwd && (c_ph == 2'd1);
            end
            default: begin
                step.up = fwd;
                step.dn = bwd;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q  <= '0;
            fault_q <= 1'b0;
        end else begin
            prev_q <= cur_i;
            if (both)
                fault_q <= 1'b1;
        end
    end

    assign prev_o  = prev_q;
    assign step_o  = step;
    assign fault_o = fault_q;
endmodule

// File: rtl/qdc_pos_counter.sv
module qdc_pos_counter
    import qdc_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  step_t        step_i,
    output logic [W-1:0] cnt_o
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (step_i.up && !step_i.both)
            cnt_q <= cnt_q + W'(1);
        else if (step_i.dn && !step_i.both)
            cnt_q <= cnt_q - W'(1);
    end

    assign cnt_o = cnt_q;
endmodule

// File: rtl/qdc_top.sv
module qdc_top
    import qdc_pkg::*;
#(
    parameter int CNT_W       = 32,
    parameter int SYNC_STAGES = 2,
    parameter int HOLD        = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [1:0]       res_i,
    input  logic             enc_a_i,
    input  logic             enc_b_i,
    output logic [CNT_W-1:0] pos_o,
    output logic             fault_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw_bits;
    logic [NCH-1:0] lvl_bits;
    quad_t          cur_st;
    quad_t          prev_st;
    step_t          step;
    logic [1:0]     filt_st;
    logic [1:0]     last_st;

    assign raw_bits = {enc_a_i, enc_b_i};

    for (genvar g = 0; g < NCH; g++) begin : g_chan
        qdc_chan_filter #(
            .SYNC_STAGES(SYNC_STAGES),
            .HOLD       (HOLD)
        ) u_filt (
            .clk    (clk),
            .rst_n  (rst_n),
            .raw_i  (raw_bits[g]),
            .level_o(lvl_bits[g])
        );
    end

    assign cur_st  = quad_t'(lvl_bits);
    assign filt_st = lvl_bits;
    assign last_st = {prev_st.a, prev_st.b};

    qdc_step_decode u_dec (
        .clk    (clk),
        .rst_n  (rst_n),
        .res_i  (res_i),
        .cur_i  (cur_st),
        .prev_o (prev_st),
        .step_o (step),
        .fault_o(fault_o)
    );

    qdc_pos_counter #(.W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .step_i(step),
        .cnt_o (pos_o)
    );
endmodule

// File: rtl/qdc_checker.sv
module qdc_checker #(
    parameter int W = 32
) (
    input logic         clk,
    input logic         rst_n,
    input logic [1:0]   res_i,
    input logic [W-1:0] pos_o,
    input logic         fault_o,
    input logic [1:0]   filt,
    input logic [1:0]   prev
);
    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (pos_o == '0) && !fault_o);

    // R10
    single_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pos_o == $past(pos_o)) || (pos_o == $past(pos_o) + W'(1))
        || (pos_o == $past(pos_o) - W'(1)));

    // R9
    fault_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fault_o |=> fault_o);

    // R9
    double_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((filt ^ prev) == 2'b11) |=> (pos_o == $past(pos_o)) && fault_o);

    // R5
    quarter_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_i == 2'b10 && filt != 2'b10 && filt != 2'b11) |=> (pos_o == $past(pos_o)));
endmodule

bind qdc_top qdc_checker #(.W(CNT_W)) u_chk (
    .clk    (clk),
    .rst_n  (rst_n),
    .res_i  (res_i),
    .pos_o  (pos_o),
    .fault_o(fault_o),
    .filt   (filt_st),
    .prev   (last_st)
);

// File: tb/tb_qdc_top.sv
module tb_qdc_top;
    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  res_i = 2'b00;
    logic        enc_a_i = 1'b0;
    logic        enc_b_i = 1'b0;
    logic [31:0] pos_o;
    logic        fault_o;

    int          n_chk = 0;
    int          n_err = 0;
    bit          done  = 1'b0;
    logic [31:0] exp_pos = '0;
    int          cur = 3;

    always #(CLK_P/2) clk = ~clk;

    qdc_top dut (
        .clk(clk), .rst_n(rst_n), .res_i(res_i),
        .enc_a_i(enc_a_i), .enc_b_i(enc_b_i),
        .pos_o(pos_o), .fault_o(fault_o)
    );

    task automatic cyc(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [1:0] ab_of(int ph);
        case (ph & 3)
            0:       return 2'b10;
            1:       return 2'b11;
            2:       return 2'b01;
            default: return 2'b00;
        endcase
    endfunction

    function automatic int delta(int p, int c, logic [1:0] m);
        bit fwd, bwd;
        fwd = (c == ((p + 1) & 3));
        bwd = (c == ((p + 3) & 3));
        case (m)
            2'b01: return (fwd && (c % 2 == 0)) ? 1 : (bwd && (c % 2 == 1)) ? -1 : 0;
            2'b10: return (fwd && c == 0) ? 1 : (bwd && c == 1) ? -1 : 0;
            default: return fwd ? 1 : bwd ? -1 : 0;
        endcase
    endfunction

    function automatic string req_of(logic [1:0] m);
        case (m)
            2'b00:   return "R3 full";
            2'b01:   return "R4 half";
            2'b10:   return "R5 quarter";
            default: return "R6 code11";
        endcase
    endfunction

    task automatic step(int dir, logic [1:0] m);
        int nx;
        nx = (cur + dir + 4) & 3;
        res_i = m;
        {enc_a_i, enc_b_i} = ab_of(nx);
        exp_pos = exp_pos + 32'(delta(cur, nx, m));
        cur = nx;
        cyc(8);
        check(req_of(m), pos_o, exp_pos);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_err++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_0042));
        cyc(3);
        check("R7 reset pos", pos_o, 32'h0);
        check("R7 reset fault", {31'h0, fault_o}, 32'h0);
        rst_n = 1'b1;
        cyc(4);

        // R1: two-clock pulse on A is rejected
        enc_a_i = 1'b1; cyc(2); enc_a_i = 1'b0; cyc(10);
        check("R1 short pulse", pos_o, exp_pos);
        // R1: three-clock pulse is accepted, then undone
        enc_a_i = 1'b1; cyc(3); enc_a_i = 1'b0; cyc(3);
        check("R1 three-clock pulse counted", pos_o, exp_pos + 32'h1);
        cyc(8);
        check("R1 pulse returns", pos_o, exp_pos);
        // R1: interrupted run restarts, final level still accepted
        enc_a_i = 1'b1; cyc(2); enc_a_i = 1'b0; cyc(1); enc_a_i = 1'b1;
        cyc(5);
        check("R1 restart not early", pos_o, exp_pos);
        cyc(6);
        exp_pos = exp_pos + 32'h1; cur = 0;
        check("R1 restart accepted", pos_o, exp_pos);

        // R2: latency of exactly six rising edges
        {enc_a_i, enc_b_i} = ab_of(1);
        cyc(5);
        check("R2 not before edge k+5", pos_o, exp_pos);
        cyc(1);
        exp_pos = exp_pos + 32'h1; cur = 1;
        check("R2 due at edge k+5", pos_o, exp_pos);
        cyc(2);

        // Directed full cycles per resolution
        for (int i = 0; i < 4; i++) step(1, 2'b00);
        for (int i = 0; i < 4; i++) step(-1, 2'b00);
        for (int i = 0; i < 4; i++) step(1, 2'b01);
        for (int i = 0; i < 4; i++) step(-1, 2'b01);
        for (int i = 0; i < 4; i++) step(1, 2'b10);
        for (int i = 0; i < 4; i++) step(-1, 2'b10);
        for (int i = 0; i < 4; i++) step(1, 2'b11);

        // Random walk
        for (int i = 0; i < 400; i++) begin
            int r;
            r = int'($urandom % 3);
            step((r == 0) ? 1 : (r == 1) ? -1 : 0, 2'($urandom % 4));
        end
        check("R9 no fault on legal walk", {31'h0, fault_o}, 32'h0);

        // R9: both channels at once
        res_i = 2'b00;
        cur = (cur + 2) & 3;
        {enc_a_i, enc_b_i} = ab_of(cur);
        cyc(8);
        check("R9 no count on double change", pos_o, exp_pos);
        check("R9 fault set", {31'h0, fault_o}, 32'h1);
        step(1, 2'b00);
        check("R9 fault sticky", {31'h0, fault_o}, 32'h1);

        // R7: reset mid-run
        rst_n = 1'b0;
        {enc_a_i, enc_b_i} = 2'b00;
        cyc(10);
        check("R7 mid reset pos", pos_o, 32'h0);
        check("R7 mid reset fault", {31'h0, fault_o}, 32'h0);
        rst_n = 1'b1;
        exp_pos = '0; cur = 3;
        cyc(4);
        check("R7 phase P3 after reset", pos_o, 32'h0);

        // R8: wrap both ways
        step(-1, 2'b00);
        check("R8 wrap below zero", pos_o, 32'hFFFF_FFFF);
        step(1, 2'b00);
        check("R8 wrap to zero", pos_o, 32'h0);

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule